// File: doc/BRIEF.md
# Multi-Window Loss Integrator with Latched Permit

The block accepts loss samples for several detector channels, one sample per clock at most, each tagged with its channel number. For every channel it keeps four running sums of increasing span: the newest sample alone, a short sliding window, a medium sliding window, and a long window. The long window is the total of the most recent completed medium-length blocks, so a very long span needs only one stored value per block and not one per sample. Every sum is recomputed when a sample for its channel arrives. Each new value is compared at once against a threshold held for that channel and that window.

Whenever any freshly computed sum lies strictly above its threshold, the beam-permit output falls and stays low. Only an acknowledge can raise it again, and the acknowledge is refused while any stored sum still exceeds its threshold. For each channel and window the block also records the largest sum seen since the last start-of-cycle pulse. These peaks can be read through a combinational readout port.

Top module: `blm_win_guard`

## Requirements
- R1: After reset, `permit` is 0, every peak reads 0 and every threshold holds the all-ones value of SW bits.
- R2: On a sample for channel c, window 0 becomes the sample value, window 1 the total of the last SHORT_LEN samples of c, and window 2 the total of the last MID_LEN samples of c. Samples that never arrived count as zero.
- R3: Window 3 of channel c is the total of its last LONG_BLKS completed blocks. A block is each run of MID_LEN consecutive samples of c, counted from reset. Window 3 changes only on the sample that completes a block.
- R4: A sample whose new sum in any window is strictly greater than that channel's threshold for the window drives `permit` low at the next clock edge. A sum equal to its threshold has no effect.
- R5: `ack` drives `permit` high at the next clock edge when no stored sum of any channel exceeds its threshold.
- R6: `ack` is ignored while any stored sum exceeds its threshold, and `permit` stays 0.
- R7: `rd_max` shows the peak for channel `rd_ch` and window `rd_win`, where `rd_win` 0 to 3 selects windows 0 to 3 as numbered in R2 and R3. The peak is the largest sum of that channel and window since reset or since the last `soc`.
- R8: `soc` clears all peaks to 0. A sample in the same cycle as `soc` is the first value of the new cycle, so its sums become the peaks.
- R9: A threshold write (`thr_we`) sets exactly one channel/window threshold, selected by `thr_ch` and `thr_win` (same window coding as R7). A low threshold on one channel does not react to samples of another channel.
- R10: Once low, `permit` stays low through any later samples until an accepted `ack`, even when those samples are below their thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A loss sample is present this cycle |
| s_ch | input | CHW | Channel of the sample |
| s_data | input | DW | Sample value |
| thr_we | input | 1 | Threshold write strobe |
| thr_ch | input | CHW | Channel of the threshold write |
| thr_win | input | 2 | Window of the threshold write |
| thr_val | input | SW | Threshold value |
| soc | input | 1 | Start-of-cycle pulse |
| ack | input | 1 | Operator acknowledge |
| permit | output | 1 | Beam permit, 1 means beam allowed |
| rd_ch | input | CHW | Peak readout channel |
| rd_win | input | 2 | Peak readout window |
| rd_max | output | SW | Peak of the selected channel and window |

## Verification
The assertions assume that `s_ch` and `thr_ch` always name an existing channel. They also assume that `ack` never arrives in the same cycle as a sample, and that sums stay far below the saturation level. The stimulus keeps to these conditions. It uses only channel numbers below CH, places each acknowledge in a cycle with no sample, and keeps sample values small enough that even the long window stays well under the SW-bit ceiling. Within these limits the stimulus covers an exact threshold match, trips in the short, sample and long windows, a refused acknowledge, and a start-of-cycle pulse that coincides with a sample.

// File: rtl/blm_pkg.sv
package blm_pkg;
    localparam int NWIN = 4;
    typedef enum logic [1:0] {
        WIN_SAMPLE = 2'd0,
        WIN_SHORT  = 2'd1,
        WIN_MID    = 2'd2,
        WIN_LONG   = 2'd3
    } win_e;
endpackage

// File: rtl/blm_ring.sv
module blm_ring #(
    parameter int CH    = 8,
    parameter int DEPTH = 4,
    parameter int W     = 12,
    localparam int CHW  = $clog2(CH),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CHW-1:0] ch,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout
);
    typedef struct packed {
        logic [CH-1:0][DEPTH-1:0][W-1:0] mem;
        logic [CH-1:0][PW-1:0]           ptr;
    } ring_t;

    ring_t ring_d, ring_q;

    // oldest entry of the selected channel, about to be overwritten
    assign dout = ring_q.mem[ch][ring_q.ptr[ch]];

    always_comb begin
        ring_d = ring_q;
        if (we) begin
            ring_d.mem[ch][ring_q.ptr[ch]] = din;
            if (ring_q.ptr[ch] == PW'(DEPTH - 1))
                ring_d.ptr[ch] = '0;
            else
                ring_d.ptr[ch] = ring_q.ptr[ch] + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    // R2: each write moves the channel's slot pointer on
    a_r2_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ring_q.ptr[$past(ch)] != $past(ring_q.ptr[ch])));
endmodule

// File: rtl/blm_thr_bank.sv
module blm_thr_bank
    import blm_pkg::*;
#(
    parameter int CH   = 8,
    parameter int SW   = 24,
    localparam int CHW = $clog2(CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [CHW-1:0]                 ch,
    input  logic [1:0]                     win,
    input  logic [SW-1:0]                  val,
    output logic [CH-1:0][NWIN-1:0][SW-1:0] thr
);
    logic [CH-1:0][NWIN-1:0][SW-1:0] thr_d, thr_q;

    always_comb begin
        thr_d = thr_q;
        if (we) thr_d[ch][win] = val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '1;
        else        thr_q <= thr_d;
    end

    assign thr = thr_q;

    // R9: a write lands on the addressed entry only
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (thr_q[$past(ch)][$past(win)] == $past(val)));
endmodule

// File: rtl/blm_win_guard.sv
module blm_win_guard
    import blm_pkg::*;
#(
    parameter int CH        = 8,
    parameter int DW        = 12,
    parameter int SW        = 24,
    parameter int SHORT_LEN = 4,
    parameter int MID_LEN   = 10,
    parameter int LONG_BLKS = 3,
    localparam int CHW      = $clog2(CH),
    localparam int CW       = $clog2(MID_LEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    input  logic [CHW-1:0] s_ch,
    input  logic [DW-1:0]  s_data,
    input  logic           thr_we,
    input  logic [CHW-1:0] thr_ch,
    input  logic [1:0]     thr_win,
    input  logic [SW-1:0]  thr_val,
    input  logic           soc,
    input  logic           ack,
    output logic           permit,
    input  logic [CHW-1:0] rd_ch,
    input  logic [1:0]     rd_win,
    output logic [SW-1:0]  rd_max
);
    typedef struct packed {
        logic [CH-1:0][NWIN-1:0][SW-1:0] sum;
        logic [CH-1:0][NWIN-1:0][SW-1:0] mx;
        logic [CH-1:0][SW-1:0]           acc;
        logic [CH-1:0][CW-1:0]           cnt;
        logic                            permit;
    } st_t;

    st_t st_d, st_q;

    logic [CH-1:0][NWIN-1:0][SW-1:0] thr;
    logic [DW-1:0]                   old_short, old_mid;
    logic [SW-1:0]                   old_blk, blk_sum, din;
    logic [NWIN-1:0][SW-1:0]         ns;
    logic                            blk_done, trip, exc_now;

    // base + add - sub, clamped to [0, all ones]
    function automatic logic [SW-1:0] sat_upd(input logic [SW-1:0] base,
                                              input logic [SW-1:0] add,
                                              input logic [SW-1:0] sub);
        logic [SW:0] t;
        t = {1'b0, base} + {1'b0, add};
        if (t < {1'b0, sub}) return '0;
        t = t - {1'b0, sub};
        if (t[SW]) return '1;
        return t[SW-1:0];
    endfunction

    blm_thr_bank #(.CH(CH), .SW(SW)) u_thr (
        .clk(clk), .rst_n(rst_n), .we(thr_we), .ch(thr_ch),
        .win(thr_win), .val(thr_val), .thr(thr)
    );

    blm_ring #(.CH(CH), .DEPTH(SHORT_LEN), .W(DW)) u_short (
        .clk(clk), .rst_n(rst_n), .we(s_valid), .ch(s_ch),
        .din(s_data), .dout(old_short)
    );

    blm_ring #(.CH(CH), .DEPTH(MID_LEN), .W(DW)) u_mid (
        .clk(clk), .rst_n(rst_n), .we(s_valid), .ch(s_ch),
        .din(s_data), .dout(old_mid)
    );

    blm_ring #(.CH(CH), .DEPTH(LONG_BLKS), .W(SW)) u_blk (
        .clk(clk), .rst_n(rst_n), .we(blk_done), .ch(s_ch),
        .din(blk_sum), .dout(old_blk)
    );

    always_comb begin
        st_d     = st_q;
        trip     = 1'b0;
        exc_now  = 1'b0;
        blk_done = 1'b0;
        din      = SW'(s_data);

        for (int c = 0; c < CH; c++)
            for (int w = 0; w < NWIN; w++)
                if (st_q.sum[c][w] > thr[c][w]) exc_now = 1'b1;

        blk_sum          = sat_upd(st_q.acc[s_ch], din, '0);
        ns[WIN_SAMPLE]   = din;
        ns[WIN_SHORT]    = sat_upd(st_q.sum[s_ch][WIN_SHORT], din, SW'(old_short));
        ns[WIN_MID]      = sat_upd(st_q.sum[s_ch][WIN_MID], din, SW'(old_mid));
        ns[WIN_LONG]     = st_q.sum[s_ch][WIN_LONG];

        if (s_valid) begin
            if (st_q.cnt[s_ch] == CW'(MID_LEN - 1)) begin
                blk_done          = 1'b1;
                ns[WIN_LONG]      = sat_upd(st_q.sum[s_ch][WIN_LONG], blk_sum, old_blk);
                st_d.acc[s_ch]    = '0;
                st_d.cnt[s_ch]    = '0;
            end else begin
                st_d.acc[s_ch]    = blk_sum;
                st_d.cnt[s_ch]    = st_q.cnt[s_ch] + CW'(1);
            end
            for (int w = 0; w < NWIN; w++) begin
                st_d.sum[s_ch][w] = ns[w];
                if (ns[w] > thr[s_ch][w]) trip = 1'b1;
            end
        end

        if (soc) st_d.mx = '0;
        if (s_valid)
            for (int w = 0; w < NWIN; w++)
                if (ns[w] > st_d.mx[s_ch][w]) st_d.mx[s_ch][w] = ns[w];

        if (trip)                 st_d.permit = 1'b0;
        else if (ack && !exc_now) st_d.permit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign permit = st_q.permit;
    assign rd_max = st_q.mx[rd_ch][rd_win];

    // R4: an exceedance removes the permit at the next edge
    a_r4_trip_drops: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !st_q.permit);
    // R5: the permit only rises after an acknowledge
    a_r5_rise_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.permit) |-> $past(ack));
    // R6: acknowledge refused while a sum is over its limit
    a_r6_ack_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && exc_now && !st_q.permit) |=> !st_q.permit);
    // R8: a bare start-of-cycle empties every peak
    a_r8_soc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && !s_valid) |=> (st_q.mx == '0));
    // R10: a removed permit holds until acknowledged
    a_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.permit && !ack) |=> !st_q.permit);
endmodule

// File: tb/blm_win_guard_bench.sv
`timescale 1ns/1ps
module blm_win_guard_bench;
    localparam int CH = 8, DW = 12, SW = 24, SL = 4, ML = 10, LB = 3;
    localparam longint TMAX = (64'd1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0, thr_we = 1'b0, soc = 1'b0, ack = 1'b0;
    logic [2:0]    s_ch = '0, thr_ch = '0, rd_ch = '0;
    logic [DW-1:0] s_data = '0;
    logic [1:0]    thr_win = '0, rd_win = '0;
    logic [SW-1:0] thr_val = '0, rd_max;
    logic          permit;

    always #10 clk = ~clk;

    blm_win_guard #(.CH(CH), .DW(DW), .SW(SW), .SHORT_LEN(SL), .MID_LEN(ML),
                    .LONG_BLKS(LB)) u_blm_win_guard (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ch(s_ch), .s_data(s_data),
        .thr_we(thr_we), .thr_ch(thr_ch), .thr_win(thr_win), .thr_val(thr_val),
        .soc(soc), .ack(ack), .permit(permit), .rd_ch(rd_ch), .rd_win(rd_win),
        .rd_max(rd_max)
    );

    typedef struct {
        int     kind;
        int     ch;
        int     win;
        longint exp;
        string  req;
    } item_t;

    item_t  sb[$];
    int     n_cmp = 0, n_bad = 0;
    bit     done = 0;
    longint thr_m[CH][4], cur_m[CH][4], max_m[CH][4];
    int     hist[CH][$];
    longint blks[CH][$];
    bit     perm_m = 0;

    function automatic longint tail_sum(int c, int n);
        longint s = 0;
        int lo = hist[c].size() - n;
        if (lo < 0) lo = 0;
        for (int i = lo; i < hist[c].size(); i++) s += hist[c][i];
        return s;
    endfunction

    function automatic longint blk_total(int c);
        longint s = 0;
        int lo = blks[c].size() - LB;
        if (lo < 0) lo = 0;
        for (int i = lo; i < blks[c].size(); i++) s += blks[c][i];
        return s;
    endfunction

    task automatic put_perm(string r);
        item_t it;
        it.kind = 0; it.ch = 0; it.win = 0; it.exp = perm_m; it.req = r;
        sb.push_back(it);
    endtask

    task automatic put_max(int c, string r);
        for (int w = 0; w < 4; w++) begin
            item_t it;
            it.kind = 1; it.ch = c; it.win = w; it.exp = max_m[c][w]; it.req = r;
            sb.push_back(it);
        end
    endtask

    task automatic sample(int c, int d, bit with_soc, string r);
        longint nsv[4];
        @(negedge clk);
        s_valid = 1'b1; s_ch = 3'(c); s_data = DW'(d); soc = with_soc;
        @(posedge clk);
        #1 s_valid = 1'b0; soc = 1'b0;
        if (with_soc)
            for (int a = 0; a < CH; a++)
                for (int w = 0; w < 4; w++) max_m[a][w] = 0;
        hist[c].push_back(d);
        if (hist[c].size() % ML == 0) blks[c].push_back(tail_sum(c, ML));
        nsv[0] = d;
        nsv[1] = tail_sum(c, SL);
        nsv[2] = tail_sum(c, ML);
        nsv[3] = blk_total(c);
        for (int w = 0; w < 4; w++) begin
            cur_m[c][w] = nsv[w];
            if (nsv[w] > thr_m[c][w]) perm_m = 0;
            if (nsv[w] > max_m[c][w]) max_m[c][w] = nsv[w];
        end
        put_perm(r);
    endtask

    task automatic pulse_ack(string r);
        bit over = 0;
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        #1 ack = 1'b0;
        for (int c = 0; c < CH; c++)
            for (int w = 0; w < 4; w++)
                if (cur_m[c][w] > thr_m[c][w]) over = 1;
        if (!over) perm_m = 1;
        put_perm(r);
    endtask

    task automatic pulse_soc(string r);
        @(negedge clk);
        soc = 1'b1;
        @(posedge clk);
        #1 soc = 1'b0;
        for (int c = 0; c < CH; c++)
            for (int w = 0; w < 4; w++) max_m[c][w] = 0;
        put_max(0, r);
        put_max(1, r);
    endtask

    task automatic set_thr(int c, int w, longint v);
        @(negedge clk);
        thr_we = 1'b1; thr_ch = 3'(c); thr_win = 2'(w); thr_val = SW'(v);
        @(posedge clk);
        #1 thr_we = 1'b0;
        thr_m[c][w] = v;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        item_t  it;
        longint act;
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.kind == 1) begin
                    rd_ch = 3'(it.ch); rd_win = 2'(it.win);
                    #0.2;
                    act = rd_max;
                end else begin
                    act = permit;
                end
                n_cmp++;
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d ch=%0d win=%0d actual=%0d expected=%0d",
                             it.req, it.kind, it.ch, it.win, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < CH; c++)
            for (int w = 0; w < 4; w++) begin
                thr_m[c][w] = TMAX; cur_m[c][w] = 0; max_m[c][w] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        put_perm("R1");
        put_max(0, "R1");
        @(negedge clk);

        pulse_ack("R5 ack after reset");

        // R2/R3/R7: three channels with different patterns, ch1 wraps the block ring
        for (int i = 0; i < 35; i++) begin
            sample(0, 100 + 7 * i, 0, "R2 ramp");
            sample(1, (i % 2) ? 40 : 900, 0, "R3 alternating");
            sample(2, 333, 0, "R2 constant");
        end
        @(negedge clk);
        put_max(0, "R7 ch0");
        put_max(1, "R3 ch1");
        put_max(2, "R7 ch2");
        @(negedge clk);

        // R4: equal does not trip, one above does
        set_thr(4, 0, 300);
        sample(4, 300, 0, "R4 equal");
        sample(4, 301, 0, "R4 above");
        set_thr(4, 0, TMAX);
        sample(4, 10, 0, "R10 stays low");
        pulse_ack("R5 clear");

        // R6: short window trip, refused ack, then accepted
        set_thr(3, 1, 500);
        for (int i = 0; i < 3; i++) sample(3, 200, 0, "R4 short trip");
        pulse_ack("R6 refused");
        set_thr(3, 1, 5000);
        pulse_ack("R5 accepted");

        // R9: low threshold on ch5 ignores ch6, then trips on ch5
        set_thr(5, 0, 50);
        sample(6, 1000, 0, "R9 other channel");
        sample(5, 60, 0, "R9 own channel");
        set_thr(5, 0, TMAX);
        pulse_ack("R5 clear ch5");

        // R3: long window trips only on the completing sample
        set_thr(7, 3, 1500);
        for (int i = 0; i < 20; i++) sample(7, 100, 0, "R3 long window");
        set_thr(7, 3, TMAX);
        pulse_ack("R5 clear ch7");

        // R8: bare start-of-cycle, then with a coincident sample
        pulse_soc("R8 soc");
        @(negedge clk);
        sample(1, 77, 1, "R8 soc+sample");
        @(negedge clk);
        put_max(1, "R8 new peak");
        put_max(0, "R8 other zero");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule